// File: doc/BRIEF.md
# Supervisor Trap Control Register Unit

This unit keeps the supervisor-level trap state of one hardware thread and decides, cycle by cycle, whether the core continues in order, enters the trap handler or returns from it. The pipeline presents the current program counter and privilege level with any requests raised by the instruction in flight: a synchronous exception with its code and faulting value, an environment call, a control-register access, or a trap return. An external device interrupt line is sampled in the same cycle.

When a trap is taken, the unit updates all of its trap registers on one clock edge. It saves the interrupted PC and privilege level, records a cause code and an optional faulting value, and stacks the interrupt enable. In the same cycle it raises a redirect strobe with the handler address and supervisor privilege. The unit does not switch stacks, page tables or general registers; that work is left to handler software. To support that software, the scratch register can be exchanged with a general register in a single access. The redirect outputs are combinational from the current inputs and state. State changes take effect at the next rising clock edge.

Top module: `sup_trap_ctrl`

## Requirements
- R1: After reset, every register (status, vector, saved PC, cause, faulting value, scratch) reads as zero and no redirect is signalled while there are no requests.
- R2: A device interrupt is ignored while the interrupt-enable bit is clear. There is no redirect, and a following read shows the cause and saved PC unchanged.
- R3: Exceptions and environment calls are taken whatever the interrupt-enable bit holds.
- R4: On any trap entry, the previous-enable bit takes the old interrupt-enable value and interrupt-enable is cleared.
- R5: On trap entry, the saved-PC register takes `pc_i` and the previous-privilege bit takes `priv_i` (0 user, 1 supervisor).
- R6: The cause register takes one of these values on trap entry: `exc_code_i` zero-extended for an exception; 8 for an environment call from user level and 9 from supervisor level; 2 for an illegal access; 0x80000009 (top bit set, code 9) for a device interrupt.
- R7: A trap raises `redirect_o` with `next_priv_o` = 1 and `next_pc_o` = the vector register with its two low bits zero. Writes to the vector register always store the two low bits as zero.
- R8: On trap entry, the faulting-value register takes `exc_tval_i` for an exception and zero for every other trap.
- R9: A trap return in supervisor mode raises `redirect_o` with `next_pc_o` = saved PC and `next_priv_o` = previous-privilege bit. It then clears the previous-privilege bit, copies previous-enable into interrupt-enable, and sets previous-enable.
- R10: The access port addresses registers by `csr_addr_i` as follows: 0 status, 1 vector, 2 saved PC, 3 cause, 4 faulting value, 5 scratch. Addresses 6 and 7 read zero and ignore writes. Op 1 (swap) returns the old value on `csr_rdata_o` in the same cycle and stores `csr_wdata_i` at the edge.
- R11: Op 2 ORs `csr_wdata_i` into the register and op 3 clears the bits set in it; both return the old value. Op 0 only reads.
- R12: An access or trap return attempted at user level (`priv_i` = 0) does not touch any register and returns zero on `csr_rdata_o`. It is instead taken as an illegal-access trap.
- R13: When requests coincide, the order is: exception, then environment call, then illegal access, then interrupt, then trap return, then access. Lower-ranked requests in that cycle have no effect. With no request, `next_pc_o` = `pc_i`+4 and `next_priv_o` = `priv_i`.
- R14: The status register places interrupt-enable at bit 1, previous-enable at bit 5 and previous-privilege at bit 8. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | XLEN | PC of the instruction in flight |
| priv_i | input | 1 | Current privilege: 0 user, 1 supervisor |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_code_i | input | CODE_W | Exception cause code |
| exc_tval_i | input | XLEN | Faulting value for the exception |
| ecall_i | input | 1 | Environment call request |
| irq_i | input | 1 | Device interrupt request |
| sret_i | input | 1 | Trap return strobe |
| csr_valid_i | input | 1 | Register access request |
| csr_op_i | input | 2 | 0 read, 1 swap, 2 set bits, 3 clear bits |
| csr_addr_i | input | 3 | Register select |
| csr_wdata_i | input | XLEN | Access write operand |
| csr_rdata_o | output | XLEN | Old value of the accessed register |
| redirect_o | output | 1 | Control transfer this cycle |
| next_pc_o | output | XLEN | PC for the next instruction |
| next_priv_o | output | 1 | Privilege for the next instruction |

## Verification
A wrong stored field shows up on the ports at the first later event that consumes it. A corrupt saved PC or previous-privilege bit appears at the next trap return, as `next_pc_o` and `next_priv_o` of that same cycle. A corrupt enable stack appears as a taken or missed interrupt in the first cycle `irq_i` is raised. The bench shadows every register and checks all outputs on every cycle, so a divergence is reported in the cycle it becomes visible. Directed readbacks also expose each field one cycle after the trap that wrote it.

// File: rtl/sup_trap_pkg.sv
package sup_trap_pkg;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_SWAP = 2'd1,
        OP_SET  = 2'd2,
        OP_CLR  = 2'd3
    } csr_op_e;

    typedef enum logic [2:0] {
        IDX_STATUS  = 3'd0,
        IDX_TVEC    = 3'd1,
        IDX_EPC     = 3'd2,
        IDX_CAUSE   = 3'd3,
        IDX_TVAL    = 3'd4,
        IDX_SCRATCH = 3'd5
    } csr_idx_e;

    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_EXC     = 3'd1,
        EV_ECALL   = 3'd2,
        EV_ILLEGAL = 3'd3,
        EV_IRQ     = 3'd4,
        EV_SRET    = 3'd5
    } event_e;

    localparam int SIE_POS  = 1;
    localparam int SPIE_POS = 5;
    localparam int SPP_POS  = 8;

    localparam int CODE_ILLEGAL  = 2;
    localparam int CODE_ECALL_U  = 8;
    localparam int CODE_ECALL_S  = 9;
    localparam int CODE_DEV_IRQ  = 9;
    localparam int LAST_IDX      = 5;

endpackage

// File: rtl/trap_select.sv
module trap_select
    import sup_trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [XLEN-1:0]   exc_tval,
    input  logic              ecall,
    input  logic              csr_valid,
    input  logic              sret,
    input  logic              irq,
    input  logic              sie,
    input  logic              priv,
    output event_e            ev,
    output logic [XLEN-1:0]   cause,
    output logic [XLEN-1:0]   tval,
    output logic              csr_en
);

    // Fixed priority: exception, ecall, illegal access, interrupt, return.
    always_comb begin
        ev    = EV_NONE;
        cause = '0;
        tval  = '0;
        if (exc_valid) begin
            ev    = EV_EXC;
            cause = XLEN'(exc_code);
            tval  = exc_tval;
        end else if (ecall) begin
            ev    = EV_ECALL;
            cause = priv ? XLEN'(CODE_ECALL_S) : XLEN'(CODE_ECALL_U);
        end else if ((csr_valid || sret) && !priv) begin
            ev    = EV_ILLEGAL;
            cause = XLEN'(CODE_ILLEGAL);
        end else if (irq && sie) begin
            ev    = EV_IRQ;
            cause = {1'b1, (XLEN-1)'(CODE_DEV_IRQ)};
        end else if (sret) begin
            ev    = EV_SRET;
        end
        csr_en = csr_valid && (ev == EV_NONE);
    end

endmodule

// File: rtl/csr_rw_port.sv
module csr_rw_port
    import sup_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            en,
    input  logic [2:0]      addr,
    input  csr_op_e         op,
    input  logic [XLEN-1:0] wdata,
    input  logic [XLEN-1:0] status_view,
    input  logic [XLEN-1:0] tvec,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] cause,
    input  logic [XLEN-1:0] tval,
    input  logic [XLEN-1:0] scratch,
    output logic [XLEN-1:0] rdata,
    output logic            wr_en,
    output logic [2:0]      wr_idx,
    output logic [XLEN-1:0] wr_val
);

    logic [XLEN-1:0] old_val;

    always_comb begin
        case (addr)
            IDX_STATUS:  old_val = status_view;
            IDX_TVEC:    old_val = tvec;
            IDX_EPC:     old_val = epc;
            IDX_CAUSE:   old_val = cause;
            IDX_TVAL:    old_val = tval;
            IDX_SCRATCH: old_val = scratch;
            default:     old_val = '0;
        endcase

        case (op)
            OP_SWAP: wr_val = wdata;
            OP_SET:  wr_val = old_val | wdata;
            OP_CLR:  wr_val = old_val & ~wdata;
            default: wr_val = old_val;
        endcase

        rdata  = en ? old_val : '0;
        wr_en  = en && (op != OP_READ) && (int'(addr) <= LAST_IDX);
        wr_idx = addr;
    end

endmodule

// File: rtl/trap_csr_regs.sv
module trap_csr_regs
    import sup_trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  event_e          ev,
    input  logic [XLEN-1:0] pc,
    input  logic            priv,
    input  logic [XLEN-1:0] new_cause,
    input  logic [XLEN-1:0] new_tval,
    input  logic            wr_en,
    input  logic [2:0]      wr_idx,
    input  logic [XLEN-1:0] wr_val,
    output logic            sie,
    output logic            spie,
    output logic            spp,
    output logic [XLEN-1:0] tvec,
    output logic [XLEN-1:0] epc,
    output logic [XLEN-1:0] cause,
    output logic [XLEN-1:0] tval,
    output logic [XLEN-1:0] scratch
);

    typedef struct packed {
        logic            sie;
        logic            spie;
        logic            spp;
        logic [XLEN-1:0] tvec;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] tval;
        logic [XLEN-1:0] scratch;
    } state_t;

    state_t state_d, state_q;
    logic   entering;

    always_comb begin
        state_d  = state_q;
        entering = (ev == EV_EXC) || (ev == EV_ECALL) ||
                   (ev == EV_ILLEGAL) || (ev == EV_IRQ);

        if (wr_en) begin
            case (wr_idx)
                IDX_STATUS: begin
                    state_d.sie  = wr_val[SIE_POS];
                    state_d.spie = wr_val[SPIE_POS];
                    state_d.spp  = wr_val[SPP_POS];
                end
                IDX_TVEC:    state_d.tvec    = {wr_val[XLEN-1:2], 2'b00};
                IDX_EPC:     state_d.epc     = wr_val;
                IDX_CAUSE:   state_d.cause   = wr_val;
                IDX_TVAL:    state_d.tval    = wr_val;
                IDX_SCRATCH: state_d.scratch = wr_val;
                default: ;
            endcase
        end

        if (entering) begin
            state_d.spie  = state_q.sie;
            state_d.sie   = 1'b0;
            state_d.spp   = priv;
            state_d.epc   = pc;
            state_d.cause = new_cause;
            state_d.tval  = new_tval;
        end else if (ev == EV_SRET) begin
            state_d.sie  = state_q.spie;
            state_d.spie = 1'b1;
            state_d.spp  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign sie     = state_q.sie;
    assign spie    = state_q.spie;
    assign spp     = state_q.spp;
    assign tvec    = state_q.tvec;
    assign epc     = state_q.epc;
    assign cause   = state_q.cause;
    assign tval    = state_q.tval;
    assign scratch = state_q.scratch;

endmodule

// File: rtl/sup_trap_ctrl.sv
module sup_trap_ctrl
    import sup_trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   pc_i,
    input  logic              priv_i,
    input  logic              exc_valid_i,
    input  logic [CODE_W-1:0] exc_code_i,
    input  logic [XLEN-1:0]   exc_tval_i,
    input  logic              ecall_i,
    input  logic              irq_i,
    input  logic              sret_i,
    input  logic              csr_valid_i,
    input  logic [1:0]        csr_op_i,
    input  logic [2:0]        csr_addr_i,
    input  logic [XLEN-1:0]   csr_wdata_i,
    output logic [XLEN-1:0]   csr_rdata_o,
    output logic              redirect_o,
    output logic [XLEN-1:0]   next_pc_o,
    output logic              next_priv_o
);

    event_e          ev;
    logic [XLEN-1:0] sel_cause, sel_tval;
    logic            csr_en;
    logic            wr_en;
    logic [2:0]      wr_idx;
    logic [XLEN-1:0] wr_val;
    logic            st_sie, st_spie, st_spp;
    logic [XLEN-1:0] st_tvec, st_epc, st_cause, st_tval, st_scratch;
    logic [XLEN-1:0] status_view;
    logic            take_trap, take_sret;

    trap_select #(.XLEN(XLEN), .CODE_W(CODE_W)) u_select (
        .exc_valid (exc_valid_i),
        .exc_code  (exc_code_i),
        .exc_tval  (exc_tval_i),
        .ecall     (ecall_i),
        .csr_valid (csr_valid_i),
        .sret      (sret_i),
        .irq       (irq_i),
        .sie       (st_sie),
        .priv      (priv_i),
        .ev        (ev),
        .cause     (sel_cause),
        .tval      (sel_tval),
        .csr_en    (csr_en)
    );

    always_comb begin
        status_view           = '0;
        status_view[SIE_POS]  = st_sie;
        status_view[SPIE_POS] = st_spie;
        status_view[SPP_POS]  = st_spp;
    end

    csr_rw_port #(.XLEN(XLEN)) u_port (
        .en          (csr_en),
        .addr        (csr_addr_i),
        .op          (csr_op_e'(csr_op_i)),
        .wdata       (csr_wdata_i),
        .status_view (status_view),
        .tvec        (st_tvec),
        .epc         (st_epc),
        .cause       (st_cause),
        .tval        (st_tval),
        .scratch     (st_scratch),
        .rdata       (csr_rdata_o),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val)
    );

    trap_csr_regs #(.XLEN(XLEN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .pc        (pc_i),
        .priv      (priv_i),
        .new_cause (sel_cause),
        .new_tval  (sel_tval),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .sie       (st_sie),
        .spie      (st_spie),
        .spp       (st_spp),
        .tvec      (st_tvec),
        .epc       (st_epc),
        .cause     (st_cause),
        .tval      (st_tval),
        .scratch   (st_scratch)
    );

    always_comb begin
        take_sret = (ev == EV_SRET);
        take_trap = (ev != EV_NONE) && !take_sret;
        redirect_o = (ev != EV_NONE);
        if (take_trap) begin
            next_pc_o   = {st_tvec[XLEN-1:2], 2'b00};
            next_priv_o = 1'b1;
        end else if (take_sret) begin
            next_pc_o   = st_epc;
            next_priv_o = st_spp;
        end else begin
            next_pc_o   = pc_i + XLEN'(4);
            next_priv_o = priv_i;
        end
    end

endmodule

// File: rtl/sup_trap_chk.sv
module sup_trap_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] pc_i,
    input logic            priv_i,
    input logic            irq_i,
    input logic            exc_valid_i,
    input logic            ecall_i,
    input logic            csr_valid_i,
    input logic            sret_i,
    input logic            redirect_o,
    input logic [XLEN-1:0] next_pc_o,
    input logic            next_priv_o,
    input logic            take_trap,
    input logic            take_sret,
    input logic            sie,
    input logic            spie,
    input logic            spp,
    input logic [XLEN-1:0] epc
);

    // R2
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !sie && !exc_valid_i && !ecall_i && !csr_valid_i && !sret_i)
        |-> !redirect_o);

    // R4
    enable_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> (!sie && (spie == $past(sie))));

    // R5
    saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |=> ((epc == $past(pc_i)) && (spp == $past(priv_i))));

    // R7
    entry_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_trap |-> (redirect_o && next_priv_o && (next_pc_o[1:0] == 2'b00)));

    // R9
    return_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_sret |-> (redirect_o && (next_pc_o == epc) && (next_priv_o == spp)));

    // R9
    return_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_sret |=> ((sie == $past(spie)) && spie && !spp));

endmodule

bind sup_trap_ctrl sup_trap_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pc_i        (pc_i),
    .priv_i      (priv_i),
    .irq_i       (irq_i),
    .exc_valid_i (exc_valid_i),
    .ecall_i     (ecall_i),
    .csr_valid_i (csr_valid_i),
    .sret_i      (sret_i),
    .redirect_o  (redirect_o),
    .next_pc_o   (next_pc_o),
    .next_priv_o (next_priv_o),
    .take_trap   (take_trap),
    .take_sret   (take_sret),
    .sie         (st_sie),
    .spie        (st_spie),
    .spp         (st_spp),
    .epc         (st_epc)
);

// File: tb/sup_trap_ctrl_bench.sv
`timescale 1ns/1ps
module sup_trap_ctrl_bench;

    localparam int XLEN = 32;
    localparam int CW   = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [XLEN-1:0] pc_i;
    logic            priv_i;
    logic            exc_valid_i;
    logic [CW-1:0]   exc_code_i;
    logic [XLEN-1:0] exc_tval_i;
    logic            ecall_i, irq_i, sret_i, csr_valid_i;
    logic [1:0]      csr_op_i;
    logic [2:0]      csr_addr_i;
    logic [XLEN-1:0] csr_wdata_i;
    logic [XLEN-1:0] csr_rdata_o;
    logic            redirect_o;
    logic [XLEN-1:0] next_pc_o;
    logic            next_priv_o;

    always #2 clk = ~clk;

    sup_trap_ctrl #(.XLEN(XLEN), .CODE_W(CW)) u_sup_trap_ctrl (
        .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .priv_i(priv_i),
        .exc_valid_i(exc_valid_i), .exc_code_i(exc_code_i), .exc_tval_i(exc_tval_i),
        .ecall_i(ecall_i), .irq_i(irq_i), .sret_i(sret_i),
        .csr_valid_i(csr_valid_i), .csr_op_i(csr_op_i), .csr_addr_i(csr_addr_i),
        .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .redirect_o(redirect_o), .next_pc_o(next_pc_o), .next_priv_o(next_priv_o)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // shadow state
    logic            m_sie, m_spie, m_spp;
    logic [XLEN-1:0] m_tvec, m_epc, m_cause, m_tval, m_scratch;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [XLEN-1:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: m_read = (XLEN'(m_sie) << 1) | (XLEN'(m_spie) << 5) | (XLEN'(m_spp) << 8);
            3'd1: m_read = m_tvec;
            3'd2: m_read = m_epc;
            3'd3: m_read = m_cause;
            3'd4: m_read = m_tval;
            3'd5: m_read = m_scratch;
            default: m_read = '0;
        endcase
    endfunction

    // 0 none, 1 exc, 2 ecall, 3 illegal, 4 irq, 5 return, 6 access
    function automatic int m_kind();
        if (exc_valid_i) return 1;
        if (ecall_i) return 2;
        if ((csr_valid_i || sret_i) && !priv_i) return 3;
        if (irq_i && m_sie) return 4;
        if (sret_i) return 5;
        if (csr_valid_i) return 6;
        return 0;
    endfunction

    task automatic step(input string tag);
        int              k;
        logic            e_red, e_priv;
        logic [XLEN-1:0] e_pc, e_rd, old, nv, e_cause, e_tval;
        #1;
        k      = m_kind();
        e_red  = (k >= 1 && k <= 5);
        e_rd   = (k == 6) ? m_read(csr_addr_i) : '0;
        if (k >= 1 && k <= 4) begin
            e_pc = m_tvec; e_priv = 1'b1;
        end else if (k == 5) begin
            e_pc = m_epc; e_priv = m_spp;
        end else begin
            e_pc = pc_i + 32'd4; e_priv = priv_i;
        end
        chk(redirect_o === e_red, tag, "redirect", XLEN'(redirect_o), XLEN'(e_red));
        chk(next_pc_o === e_pc, tag, "next_pc", next_pc_o, e_pc);
        chk(next_priv_o === e_priv, tag, "next_priv", XLEN'(next_priv_o), XLEN'(e_priv));
        chk(csr_rdata_o === e_rd, tag, "rdata", csr_rdata_o, e_rd);
        e_cause = (k == 1) ? XLEN'(exc_code_i) : (k == 2) ? (priv_i ? 32'd9 : 32'd8) :
                  (k == 3) ? 32'd2 : 32'h8000_0009;
        e_tval  = (k == 1) ? exc_tval_i : '0;
        @(posedge clk);
        if (k >= 1 && k <= 4) begin
            m_spie = m_sie; m_sie = 1'b0; m_spp = priv_i;
            m_epc = pc_i; m_cause = e_cause; m_tval = e_tval;
        end else if (k == 5) begin
            m_sie = m_spie; m_spie = 1'b1; m_spp = 1'b0;
        end else if (k == 6 && csr_op_i != 2'd0) begin
            old = m_read(csr_addr_i);
            case (csr_op_i)
                2'd1: nv = csr_wdata_i;
                2'd2: nv = old | csr_wdata_i;
                default: nv = old & ~csr_wdata_i;
            endcase
            case (csr_addr_i)
                3'd0: begin m_sie = nv[1]; m_spie = nv[5]; m_spp = nv[8]; end
                3'd1: m_tvec = {nv[XLEN-1:2], 2'b00};
                3'd2: m_epc = nv;
                3'd3: m_cause = nv;
                3'd4: m_tval = nv;
                3'd5: m_scratch = nv;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle_in();
        exc_valid_i = 0; exc_code_i = '0; exc_tval_i = '0; ecall_i = 0;
        irq_i = 0; sret_i = 0; csr_valid_i = 0; csr_op_i = 2'd0;
        csr_addr_i = '0; csr_wdata_i = '0;
    endtask

    task automatic acc(input string tag, input logic p, input logic [1:0] op,
                       input logic [2:0] a, input logic [XLEN-1:0] wd);
        idle_in();
        priv_i = p; csr_valid_i = 1; csr_op_i = op; csr_addr_i = a; csr_wdata_i = wd;
        step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7331));
        m_sie = 0; m_spie = 0; m_spp = 0;
        m_tvec = '0; m_epc = '0; m_cause = '0; m_tval = '0; m_scratch = '0;
        idle_in(); pc_i = 32'h100; priv_i = 1'b1; rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 6; a++) acc("R1", 1, 2'd0, 3'(a), '0);
        idle_in(); step("R1");

        // R7 vector write forces low bits, R10 swap returns old
        acc("R10", 1, 2'd1, 3'd1, 32'h8000_0103);
        acc("R7", 1, 2'd0, 3'd1, '0);
        chk(csr_rdata_o === 32'h8000_0100, "R7", "vector low bits", csr_rdata_o, 32'h8000_0100);
        acc("R10", 1, 2'd1, 3'd5, 32'h0000_1234);
        acc("R10", 1, 2'd1, 3'd5, 32'h0000_ABCD);
        acc("R10", 1, 2'd1, 3'd6, 32'hFFFF_FFFF);
        acc("R10", 1, 2'd0, 3'd6, '0);

        // R2 masked interrupt
        idle_in(); irq_i = 1; priv_i = 0; pc_i = 32'h200; step("R2");
        acc("R2", 1, 2'd0, 3'd3, '0);
        acc("R2", 1, 2'd0, 3'd2, '0);

        // R11 set enable, R14 layout
        acc("R11", 1, 2'd2, 3'd0, 32'h0000_0002);
        acc("R14", 1, 2'd0, 3'd0, '0);
        chk(csr_rdata_o === 32'h2, "R14", "status after set", csr_rdata_o, 32'h2);

        // R4 R5 R6 interrupt from user level
        idle_in(); irq_i = 1; priv_i = 0; pc_i = 32'h400; step("R4");
        acc("R4", 1, 2'd0, 3'd0, '0);
        chk(csr_rdata_o === 32'h20, "R4", "status after irq", csr_rdata_o, 32'h20);
        acc("R5", 1, 2'd0, 3'd2, '0);
        chk(csr_rdata_o === 32'h400, "R5", "saved pc", csr_rdata_o, 32'h400);
        acc("R6", 1, 2'd0, 3'd3, '0);
        chk(csr_rdata_o === 32'h8000_0009, "R6", "irq cause", csr_rdata_o, 32'h8000_0009);

        // R3 ecall with enable clear, R6 code 9
        idle_in(); ecall_i = 1; priv_i = 1; pc_i = 32'h500; step("R3");
        acc("R6", 1, 2'd0, 3'd3, '0);
        chk(csr_rdata_o === 32'd9, "R6", "ecall cause", csr_rdata_o, 32'd9);

        // R8 page fault value
        idle_in(); exc_valid_i = 1; exc_code_i = 4'd13; exc_tval_i = 32'h0DEA_D000;
        priv_i = 0; pc_i = 32'h600; step("R8");
        acc("R8", 1, 2'd0, 3'd4, '0);
        chk(csr_rdata_o === 32'h0DEA_D000, "R8", "fault value", csr_rdata_o, 32'h0DEA_D000);

        // R9 return to user at 0x600
        idle_in(); sret_i = 1; priv_i = 1; pc_i = 32'h700; step("R9");
        acc("R9", 1, 2'd0, 3'd0, '0);

        // R12 user access is illegal, scratch untouched
        acc("R12", 0, 2'd1, 3'd5, 32'h5555_5555);
        acc("R12", 1, 2'd0, 3'd5, '0);
        chk(csr_rdata_o === 32'h0000_ABCD, "R12", "scratch kept", csr_rdata_o, 32'h0000_ABCD);
        idle_in(); sret_i = 1; priv_i = 0; step("R12");

        // R13 coincident requests
        acc("R11", 1, 2'd2, 3'd0, 32'h2);
        idle_in(); exc_valid_i = 1; exc_code_i = 4'd15; irq_i = 1; csr_valid_i = 1;
        csr_op_i = 2'd1; csr_addr_i = 3'd5; csr_wdata_i = 32'h1; priv_i = 1; step("R13");
        acc("R13", 1, 2'd0, 3'd5, '0);
        acc("R11", 1, 2'd3, 3'd5, 32'h0000_000F);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            priv_i      = ($urandom % 4) != 0;
            pc_i        = {$urandom, 2'b00} & 32'hFFFF_FFFC;
            exc_valid_i = ($urandom % 10) == 0;
            exc_code_i  = 4'($urandom);
            exc_tval_i  = $urandom;
            ecall_i     = ($urandom % 12) == 0;
            irq_i       = ($urandom % 4) == 0;
            sret_i      = ($urandom % 10) == 0;
            csr_valid_i = ($urandom % 2) == 0;
            csr_op_i    = 2'($urandom);
            csr_addr_i  = 3'($urandom);
            csr_wdata_i = $urandom;
            step("R13");
        end

        finish_run();
    end

endmodule